// File: doc/BRIEF.md
# Instruction Fetch Breakpoint Unit

This block is the fetch-address breakpoint comparator of a pipelined CPU that has delayed branches. Every channel holds a break address, an address mask and a small control word. The block watches the CPU's issue stream. Each issue event carries the fetch address and a flag that says whether the instruction really executes. It also carries flags that mark a delayed branch and whether that branch is taken. When an executed instruction matches an armed channel, the block raises a one-cycle user-break interrupt request and sets that channel's sticky flag.

Each channel can break before the matching instruction executes or just after it completes. Fetches that are issued but never executed are ignored completely. These are wrong-path fetches at a branch and fetches abandoned at an interrupt transition. When the hit lands on a taken delayed branch or on its delay slot, the request is held back until the first instruction at the branch target. A delayed branch that is not taken creates no delay slot.

Configuration is written through a simple register port, one channel and one register select per write. A channel whose address has bit 0 set can never break. A channel that selects the internal data bus together with fetch cycles can never break either.

Top module: `ifetch_brk`

## Requirements
- R1: With control bit 0 clear (break before execution), an executed instruction whose address matches an armed channel, and which is neither a taken delayed branch nor a delay slot, makes `brk_irq` high for exactly the one cycle after the issue event. The same edge sets that channel's bit in `brk_flag`.
- R2: With control bit 0 set (break after execution), a match is not reported at its own event. It is reported in the cycle after the next executed instruction that is not a delay slot.
- R3: While bit 0 of a channel's break address is 1, that channel never raises a request, whatever the issued address.
- R4: An issue event with `iss_exec` low never produces a request. It also does not count as the "next instruction" that releases a held request.
- R5: A match on a taken delayed branch (`iss_dbr` and `iss_taken` high), or on the executed instruction that follows it (its delay slot), is reported only in the cycle after the next executed instruction after the delay slot. This applies in both modes.
- R6: After a delayed branch that is not taken, the next executed instruction is treated as an ordinary instruction, and its break is delivered as in R1 or R2.
- R7: Writes to register select 2 (data value) are accepted and have no effect on matching.
- R8: A channel whose control bit 1 is set (internal data bus selected) never raises a fetch break.
- R9: Address bits where the mask register holds 1 are ignored in the comparison. Control bit 2 arms fetch breaks; with it clear, the channel never matches.
- R10: A write to register select 4 clears each flag bit whose data bit is 0 and leaves bits written 1 unchanged. A flag being set by a request on the same edge stays set.
- R11: When several channels are reported at the same event, all their flags are set and a single one-cycle `brk_irq` pulse is issued.
- R12: After reset, `brk_irq` is 0, `brk_flag` is all zero, and no channel is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CW | Channel addressed by the write |
| cfg_reg | input | 3 | Register select: 0 address, 1 mask, 2 data value, 3 control, 4 flag clear |
| cfg_wdata | input | AW | Write data; control uses bits [2:0] (0 after-execution, 1 internal bus, 2 fetch arm) |
| iss_valid | input | 1 | An instruction issue event is present |
| iss_exec | input | 1 | The issued instruction executes (low for overrun fetches) |
| iss_addr | input | AW | Fetch address of the issued instruction |
| iss_dbr | input | 1 | The issued instruction is a delayed branch |
| iss_taken | input | 1 | That delayed branch is taken |
| brk_irq | output | 1 | One-cycle user-break interrupt request |
| brk_flag | output | NCH | Sticky per-channel match flags |

## Verification
The hardest case to reach from the ports is a held request that meets further events before it is released. Examples are a taken branch hit followed by an overrun fetch and then the delay slot, or an after-execution hit on a delay slot while a deferred hit from the branch is still pending. The stimulus builds explicit branch, slot, wrong-path and target sequences, including untaken branches and idle gaps. A behavioural model in the bench tracks the delay-slot state and the held requests and is compared with both outputs on every clock.

// File: rtl/ifetch_brk.sv
module ifetch_brk #(
  parameter int NCH = 2,
  parameter int AW  = 32,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CW-1:0]  cfg_ch,
  input  logic [2:0]     cfg_reg,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic           iss_valid,
  input  logic           iss_exec,
  input  logic [AW-1:0]  iss_addr,
  input  logic           iss_dbr,
  input  logic           iss_taken,
  output logic           brk_irq,
  output logic [NCH-1:0] brk_flag
);

  logic [AW-1:0]  bar_q [NCH];
  logic [AW-1:0]  amr_q [NCH];
  logic [2:0]     ctl_q [NCH];
  logic [NCH-1:0] hit, now_m, new_p, fire_v, pend_f, clr_m;
  logic           slot_q, ev, br_t, defer, rel;

  assign ev    = iss_valid & iss_exec;
  assign br_t  = iss_dbr & iss_taken;
  assign defer = slot_q | br_t;
  assign rel   = (|pend_f) & ~slot_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bar_q[c] <= '0;
        amr_q[c] <= '0;
        ctl_q[c] <= '0;
      end else if (cfg_we && cfg_ch == CW'(c)) begin
        case (cfg_reg)
          3'd0: bar_q[c] <= cfg_wdata;
          3'd1: amr_q[c] <= cfg_wdata;
          3'd3: ctl_q[c] <= cfg_wdata[2:0];
          default: ;
        endcase
      end
    end

    assign hit[c]   = ev & ctl_q[c][2] & ~ctl_q[c][1] & ~bar_q[c][0] &
                      (((iss_addr ^ bar_q[c]) & ~amr_q[c]) == '0);
    assign now_m[c] = hit[c] & ~ctl_q[c][0] & ~defer;
    assign new_p[c] = hit[c] & ~now_m[c];

    assert_flag_with_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_flag[c]) |-> brk_irq);
  end

  assign fire_v = ev ? (now_m | (rel ? pend_f : '0)) : '0;
  assign clr_m  = (cfg_we && cfg_reg == 3'd4) ? cfg_wdata[NCH-1:0] : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q   <= 1'b0;
      pend_f   <= '0;
      brk_irq  <= 1'b0;
      brk_flag <= '0;
    end else begin
      if (ev) begin
        slot_q <= br_t & ~slot_q;
        pend_f <= (rel ? '0 : pend_f) | new_p;
      end
      brk_irq  <= |fire_v;
      brk_flag <= (brk_flag & clr_m) | fire_v;
    end
  end

  assert_no_overrun_break_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_valid && iss_exec) |=> !brk_irq);

  assert_slot_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && slot_q) |=> !brk_irq);

  assert_irq_sets_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> (brk_flag != '0));

endmodule

// File: tb/tb_ifetch_brk.sv
module tb_ifetch_brk;
  localparam int NCH = 2;
  localparam int AW  = 32;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [0:0] cfg_ch = 0;
  logic [2:0] cfg_reg = 0;
  logic [AW-1:0] cfg_wdata = 0;
  logic iss_valid = 0, iss_exec = 0, iss_dbr = 0, iss_taken = 0;
  logic [AW-1:0] iss_addr = 0;
  logic brk_irq;
  logic [NCH-1:0] brk_flag;

  always #2 clk = ~clk;

  ifetch_brk #(.NCH(NCH), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_reg(cfg_reg),
    .cfg_wdata(cfg_wdata), .iss_valid(iss_valid), .iss_exec(iss_exec),
    .iss_addr(iss_addr), .iss_dbr(iss_dbr), .iss_taken(iss_taken),
    .brk_irq(brk_irq), .brk_flag(brk_flag));

  // reference model
  logic [AW-1:0] m_bar [NCH];
  logic [AW-1:0] m_msk [NCH];
  logic [2:0]    m_ctl [NCH];
  bit m_slot, m_irq;
  bit m_pend [NCH];
  bit m_flag [NCH];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_slot = 0; m_irq = 0;
      for (int c = 0; c < NCH; c++) begin
        m_bar[c] = 0; m_msk[c] = 0; m_ctl[c] = 0; m_pend[c] = 0; m_flag[c] = 0;
      end
    end else begin
      bit fire [NCH];
      bit was_slot, any_pend;
      m_irq = 0;
      for (int c = 0; c < NCH; c++) fire[c] = 0;
      if (iss_valid && iss_exec) begin
        was_slot = m_slot;
        any_pend = 0;
        for (int c = 0; c < NCH; c++) if (m_pend[c]) any_pend = 1;
        if (any_pend && !was_slot)
          for (int c = 0; c < NCH; c++) if (m_pend[c]) begin fire[c] = 1; m_pend[c] = 0; end
        for (int c = 0; c < NCH; c++) begin
          bit h;
          h = m_ctl[c][2] && !m_ctl[c][1] && !m_bar[c][0] &&
              (((iss_addr ^ m_bar[c]) & ~m_msk[c]) == 0);
          if (h) begin
            if (!m_ctl[c][0] && !was_slot && !(iss_dbr && iss_taken)) fire[c] = 1;
            else m_pend[c] = 1;
          end
        end
        m_slot = (iss_dbr && iss_taken && !was_slot);
      end
      if (cfg_we && cfg_reg == 4)
        for (int c = 0; c < NCH; c++) if (!cfg_wdata[c]) m_flag[c] = 0;
      for (int c = 0; c < NCH; c++) if (fire[c]) begin m_flag[c] = 1; m_irq = 1; end
      if (cfg_we) begin
        case (cfg_reg)
          0: m_bar[cfg_ch] = cfg_wdata;
          1: m_msk[cfg_ch] = cfg_wdata;
          3: m_ctl[cfg_ch] = cfg_wdata[2:0];
          default: ;
        endcase
      end
    end
  end

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R12";
  bit started = 0;

  function automatic logic [NCH-1:0] mflags();
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[c] = m_flag[c];
    return v;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (started) begin
      n_cmp++;
      if (brk_irq !== m_irq || brk_flag !== mflags()) begin
        n_bad++;
        $display("FAIL %s cycle %0d: irq=%b flag=%b expected irq=%b flag=%b",
                 cur_req, cyc, brk_irq, brk_flag, m_irq, mflags());
      end
    end
  end

  task automatic direct(string rq, bit exp_irq, logic [NCH-1:0] exp_flag);
    n_cmp++;
    if (brk_irq !== exp_irq || brk_flag !== exp_flag) begin
      n_bad++;
      $display("FAIL %s direct: irq=%b flag=%b expected irq=%b flag=%b",
               rq, brk_irq, brk_flag, exp_irq, exp_flag);
    end
  endtask

  task automatic wr(int ch, int rg, logic [AW-1:0] d);
    cfg_we = 1; cfg_ch = ch[0:0]; cfg_reg = rg[2:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic iss(logic [AW-1:0] a, bit ex = 1, bit db = 0, bit tk = 0);
    iss_valid = 1; iss_exec = ex; iss_addr = a; iss_dbr = db; iss_taken = tk;
    @(negedge clk);
    iss_valid = 0; iss_exec = 0; iss_dbr = 0; iss_taken = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(int ch, logic [AW-1:0] a, logic [AW-1:0] m, logic [2:0] ct);
    wr(ch, 0, a); wr(ch, 1, m); wr(ch, 3, {29'd0, ct});
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    started = 1;
    direct("R12", 0, 2'b00);
    rst_n = 1;
    idle(1);
    cur_req = "R12"; iss(32'h100); idle(1);
    direct("R12", 0, 2'b00);

    cur_req = "R1"; arm(0, 32'h100, 0, 3'b100);
    iss(32'h0FC); iss(32'h100);
    direct("R1", 1, 2'b01);
    iss(32'h104); idle(1); wr(0, 4, 0);

    cur_req = "R2"; wr(0, 3, 32'h5);
    iss(32'h100); idle(3);
    direct("R2", 0, 2'b00);
    iss(32'h104);
    direct("R2", 1, 2'b01);
    idle(1); wr(0, 4, 0);

    cur_req = "R4"; iss(32'h100, 0); idle(1);
    direct("R4", 0, 2'b00);
    iss(32'h100); iss(32'h200, 0); idle(1);
    direct("R4", 0, 2'b00);
    iss(32'h108); idle(1); wr(0, 4, 0);

    cur_req = "R5"; wr(0, 3, 32'h4);
    iss(32'h100, 1, 1, 1); iss(32'h104); iss(32'h300, 0);
    direct("R5", 0, 2'b00);
    iss(32'h800);
    direct("R5", 1, 2'b01);
    iss(32'h0F0, 1, 1, 1); iss(32'h100); iss(32'h900);
    direct("R5", 1, 2'b01);
    wr(0, 3, 32'h5);
    iss(32'h100, 1, 1, 1); iss(32'h100); iss(32'h400, 0); iss(32'hA00);
    idle(1); wr(0, 4, 0);

    cur_req = "R6"; wr(0, 3, 32'h4);
    iss(32'h0F0, 1, 1, 0); iss(32'h100);
    direct("R6", 1, 2'b01);
    iss(32'h0F0, 1, 1, 0); wr(0, 3, 32'h5); iss(32'h100); iss(32'h104);
    direct("R6", 1, 2'b01);
    idle(1); wr(0, 4, 0);

    cur_req = "R3"; arm(0, 32'h101, 0, 3'b100);
    iss(32'h100); iss(32'h101); idle(1);
    direct("R3", 0, 2'b00);

    cur_req = "R7"; arm(0, 32'h100, 0, 3'b100);
    wr(0, 2, 32'h0); wr(0, 2, 32'hFFFF_FFFF); iss(32'h100);
    direct("R7", 1, 2'b01);
    idle(1); wr(0, 4, 0);

    cur_req = "R8"; wr(0, 3, 32'h6); iss(32'h100); idle(1);
    direct("R8", 0, 2'b00);

    cur_req = "R9"; arm(1, 32'h2000, 32'hFF, 3'b100);
    iss(32'h2040);
    direct("R9", 1, 2'b10);
    iss(32'h2140); idle(1);
    wr(1, 3, 32'h0); iss(32'h2000); idle(1);
    direct("R9", 0, 2'b10);

    cur_req = "R10"; arm(0, 32'h100, 0, 3'b100);
    iss(32'h100); idle(1);
    direct("R10", 0, 2'b11);
    wr(0, 4, 32'h2);
    direct("R10", 0, 2'b10);
    arm(1, 32'h200, 0, 3'b100);
    cfg_we = 1; cfg_ch = 0; cfg_reg = 4; cfg_wdata = 0;
    iss_valid = 1; iss_exec = 1; iss_addr = 32'h200;
    @(negedge clk);
    cfg_we = 0; iss_valid = 0; iss_exec = 0;
    direct("R10", 1, 2'b10);
    wr(0, 4, 0);

    cur_req = "R11"; arm(1, 32'h100, 0, 3'b100);
    iss(32'h100);
    direct("R11", 1, 2'b11);
    idle(1);
    direct("R11", 0, 2'b11);
    wr(0, 4, 0);

    idle(2);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: expected completion, got hang");
    summary();
  end
endmodule